// File: doc/BRIEF.md
# Pipeline Exception Commit Controller

This block resolves traps for an in-order pipeline with fetch, decode, execute, memory and writeback stages. A fault found in fetch, decode or execute does not redirect the machine when it is seen. The controller records a pending exception and its cause next to the instruction, and moves that record down the pipe in step with the instruction. The decision is made only when the instruction reaches the memory stage, which is the commit point. There, an asynchronous interrupt from outside can also be injected.

When a trap is taken, the controller raises a kill line for every tracked stage and asserts a redirect strobe. The fetch unit responds to the strobe by loading the handler address, given by parameter `HANDLER_PC`. On the next clock edge the controller writes the cause register and the exception-PC register. A separate qualifier tells the memory stage whether its instruction may perform its memory write and its register writeback.

Top module: `exc_commit_ctrl`

## Requirements
- R1: No trap is taken while a flagged instruction is still in fetch, decode or execute. `redirect_o` rises only when the trap is decided at the memory stage.
- R2: Cause codes are 0 for interrupt, 1 for fetch address fault (raised in fetch), 2 for illegal opcode (decode), 3 for overflow (execute) and 4 for data address fault (memory).
- R3: When one instruction raises faults in several stages, the cause from the earliest stage is kept.
- R4: An interrupt at the commit point overrides every pipelined exception. It records cause 0 and the memory-stage PC when that stage is valid.
- R5: In the cycle a trap is decided, `redirect_o` is 1 and all bits of `kill_o` are 1. In the next cycle `cause_o` and `epc_o` show the trap's cause and PC.
- R6: `commit_ok_o` is 1 only for a valid memory-stage instruction that carries no exception and is not being interrupted.
- R7: A stage whose valid bit is 0 neither raises nor passes on an exception, whatever its event input is.
- R8: An interrupt taken while the memory stage is empty records the PC of the oldest valid stage, searching execute, then decode, then fetch. With no valid stage it records the fetch PC.
- R9: A trap clears every carried exception record, so younger instructions that were in flight cannot trap afterwards on faults recorded before the flush.
- R10: After reset `cause_o` and `epc_o` are 0. Without a trap they keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_i | input | 1 | External interrupt request, sampled at commit |
| f_valid_i | input | 1 | Fetch stage holds an instruction |
| d_valid_i | input | 1 | Decode stage holds an instruction |
| e_valid_i | input | 1 | Execute stage holds an instruction |
| m_valid_i | input | 1 | Memory stage holds an instruction |
| f_pc_i | input | PC_W | Fetch stage PC |
| d_pc_i | input | PC_W | Decode stage PC |
| e_pc_i | input | PC_W | Execute stage PC |
| m_pc_i | input | PC_W | Memory stage PC |
| f_fetch_fault_i | input | 1 | Instruction fetch address fault |
| d_illegal_i | input | 1 | Illegal opcode detected in decode |
| e_overflow_i | input | 1 | Arithmetic overflow in execute |
| m_data_fault_i | input | 1 | Data address fault in memory |
| kill_o | output | 4 | Flush per stage; bit 0 fetch, bit 1 decode, bit 2 execute, bit 3 memory |
| redirect_o | output | 1 | Fetch must load `HANDLER_PC` |
| commit_ok_o | output | 1 | Memory-stage instruction may write memory and the register file |
| cause_o | output | 3 | Cause register |
| epc_o | output | PC_W | Exception-PC register |

## Verification
The bench targets the cases that a wrong design handles in a visible way:
- A fault raised early. A controller that traps too early redirects while the flagged instruction is still in decode or execute.
- A fault raised in a later stage. A controller with the priority reversed reports the later stage's cause.
- An interrupt that arrives while the memory stage holds a faulting instruction. A controller with the priority reversed reports that instruction's cause.
- Bubbles with their fault lines high. A design that does not gate records with the valid bit traps on an empty slot.
- An interrupt over an empty memory stage. A design with the wrong search order records the wrong PC.
- A younger faulting instruction that survives a flush. A design that does not clear records on a flush traps a second time from stale state.

// File: rtl/exc_ctl_pkg.sv
`timescale 1ns/1ps
package exc_ctl_pkg;

    // Tracked stages: fetch, decode, execute, memory (commit)
    localparam int unsigned N_STAGES  = 4;
    localparam int unsigned COMMIT_ST = N_STAGES - 1;
    localparam int unsigned CAUSE_W   = 3;

    typedef enum logic [CAUSE_W-1:0] {
        CAUSE_IRQ     = 3'd0,
        CAUSE_IFETCH  = 3'd1,
        CAUSE_ILLEGAL = 3'd2,
        CAUSE_OVF     = 3'd3,
        CAUSE_DFAULT  = 3'd4
    } cause_e;

    typedef struct packed {
        logic   pend;
        cause_e cause;
    } exc_rec_t;

    localparam exc_rec_t REC_NONE = '{pend: 1'b0, cause: CAUSE_IRQ};

    // Cause raised locally by a given stage index
    function automatic cause_e stage_cause(int unsigned s);
        case (s)
            0:       return CAUSE_IFETCH;
            1:       return CAUSE_ILLEGAL;
            2:       return CAUSE_OVF;
            default: return CAUSE_DFAULT;
        endcase
    endfunction

    // Earlier record wins; bubbles hold nothing
    function automatic exc_rec_t merge_rec(exc_rec_t carried, logic valid,
                                           logic ev, cause_e own);
        exc_rec_t r;
        r = REC_NONE;
        if (valid) begin
            if (carried.pend)  r = carried;
            else if (ev)       r = '{pend: 1'b1, cause: own};
        end
        return r;
    endfunction

endpackage

// File: rtl/exc_stage_track.sv
`timescale 1ns/1ps
module exc_stage_track
    import exc_ctl_pkg::*;
#(
    parameter cause_e OWN_CAUSE = CAUSE_IFETCH
) (
    input  logic     clk,
    input  logic     rst,
    input  logic     kill_i,
    input  logic     valid_i,
    input  logic     event_i,
    input  exc_rec_t carry_in_i,
    output exc_rec_t merged_o
);

    exc_rec_t carried_q;

    always_ff @(posedge clk) begin
        if (rst || kill_i) carried_q <= REC_NONE;
        else               carried_q <= carry_in_i;
    end

    assign merged_o = merge_rec(carried_q, valid_i, event_i, OWN_CAUSE);

    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        kill_i |=> !carried_q.pend);

    // R7
    bubble_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !valid_i |-> !merged_o.pend);

    // R3
    older_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (carried_q.pend && valid_i) |-> (merged_o.pend && merged_o.cause == carried_q.cause));

endmodule

// File: rtl/exc_commit_arb.sv
`timescale 1ns/1ps
module exc_commit_arb
    import exc_ctl_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          irq_i,
    input  logic [N_STAGES-1:0]           valid_i,
    input  logic [N_STAGES-1:0][PC_W-1:0] pc_i,
    input  exc_rec_t                      commit_rec_i,
    output logic                          trap_o,
    output cause_e                        cause_o,
    output logic [PC_W-1:0]               trap_pc_o,
    output logic                          commit_ok_o
);

    logic found;

    always_comb begin
        trap_o      = irq_i | commit_rec_i.pend;
        cause_o     = irq_i ? CAUSE_IRQ : commit_rec_i.cause;
        commit_ok_o = valid_i[COMMIT_ST] & ~trap_o;
        // oldest valid stage, default to fetch PC
        found     = 1'b0;
        trap_pc_o = pc_i[0];
        for (int s = N_STAGES - 1; s >= 0; s--) begin
            if (!found && valid_i[s]) begin
                found     = 1'b1;
                trap_pc_o = pc_i[s];
            end
        end
    end

    // R8
    empty_commit_pc_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_i && !valid_i[COMMIT_ST] && valid_i[COMMIT_ST-1]) |-> trap_pc_o == pc_i[COMMIT_ST-1]);

endmodule

// File: rtl/exc_trap_regs.sv
`timescale 1ns/1ps
module exc_trap_regs
    import exc_ctl_pkg::*;
#(
    parameter int unsigned PC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            trap_i,
    input  cause_e          cause_i,
    input  logic [PC_W-1:0] pc_i,
    output cause_e          cause_q,
    output logic [PC_W-1:0] epc_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cause_q <= CAUSE_IRQ;
            epc_q   <= '0;
        end else if (trap_i) begin
            cause_q <= cause_i;
            epc_q   <= pc_i;
        end
    end

    // R10
    hold_regs_chk: assert property (@(posedge clk) disable iff (rst)
        !trap_i |=> ($stable(cause_q) && $stable(epc_q)));

    // R5
    load_regs_chk: assert property (@(posedge clk) disable iff (rst)
        trap_i |=> (cause_q == $past(cause_i) && epc_q == $past(pc_i)));

endmodule

// File: rtl/exc_commit_ctrl.sv
`timescale 1ns/1ps
module exc_commit_ctrl
    import exc_ctl_pkg::*;
#(
    parameter int unsigned    PC_W       = 32,
    parameter logic [PC_W-1:0] HANDLER_PC = 32'h0000_0100
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                irq_i,
    input  logic                f_valid_i,
    input  logic                d_valid_i,
    input  logic                e_valid_i,
    input  logic                m_valid_i,
    input  logic [PC_W-1:0]     f_pc_i,
    input  logic [PC_W-1:0]     d_pc_i,
    input  logic [PC_W-1:0]     e_pc_i,
    input  logic [PC_W-1:0]     m_pc_i,
    input  logic                f_fetch_fault_i,
    input  logic                d_illegal_i,
    input  logic                e_overflow_i,
    input  logic                m_data_fault_i,
    output logic [3:0]          kill_o,
    output logic                redirect_o,
    output logic                commit_ok_o,
    output logic [CAUSE_W-1:0]  cause_o,
    output logic [PC_W-1:0]     epc_o
);

    logic [N_STAGES-1:0]           st_valid;
    logic [N_STAGES-1:0]           st_event;
    logic [N_STAGES-1:0][PC_W-1:0] st_pc;
    exc_rec_t                      merged   [N_STAGES];
    exc_rec_t                      chain_in [N_STAGES];
    logic                          trap;
    cause_e                        trap_cause;
    cause_e                        cause_q;
    logic [PC_W-1:0]               trap_pc;

    assign st_valid = {m_valid_i, e_valid_i, d_valid_i, f_valid_i};
    assign st_event = {m_data_fault_i, e_overflow_i, d_illegal_i, f_fetch_fault_i};
    assign st_pc    = {m_pc_i, e_pc_i, d_pc_i, f_pc_i};

    genvar s;
    generate
        for (s = 0; s < N_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                assign chain_in[s] = REC_NONE;
            end else begin : g_next
                assign chain_in[s] = merged[s-1];
            end
            exc_stage_track #(
                .OWN_CAUSE (stage_cause(s))
            ) u_track (
                .clk        (clk),
                .rst        (rst),
                .kill_i     (trap),
                .valid_i    (st_valid[s]),
                .event_i    (st_event[s]),
                .carry_in_i (chain_in[s]),
                .merged_o   (merged[s])
            );
        end
    endgenerate

    exc_commit_arb #(.PC_W(PC_W)) u_arb (
        .clk          (clk),
        .rst          (rst),
        .irq_i        (irq_i),
        .valid_i      (st_valid),
        .pc_i         (st_pc),
        .commit_rec_i (merged[COMMIT_ST]),
        .trap_o       (trap),
        .cause_o      (trap_cause),
        .trap_pc_o    (trap_pc),
        .commit_ok_o  (commit_ok_o)
    );

    exc_trap_regs #(.PC_W(PC_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .trap_i  (trap),
        .cause_i (trap_cause),
        .pc_i    (trap_pc),
        .cause_q (cause_q),
        .epc_q   (epc_o)
    );

    assign kill_o     = {N_STAGES{trap}};
    assign redirect_o = trap;
    assign cause_o    = cause_q;

    // R6
    commit_vs_trap_chk: assert property (@(posedge clk) disable iff (rst)
        commit_ok_o |-> (!redirect_o && m_valid_i));

    // R4
    irq_wins_chk: assert property (@(posedge clk) disable iff (rst)
        irq_i |=> cause_o == 3'd0);

endmodule

// File: tb/tb_exc_commit_ctrl.sv
`timescale 1ns/1ps
module tb_exc_commit_ctrl;

    localparam logic [31:0] HANDLER = 32'h0000_0100;
    // {fetch_fault, illegal, overflow, data_fault, irq, expected_cause[2:0]}
    localparam int NVEC = 11;
    localparam logic [7:0] VEC [NVEC] = '{
        8'b00000_000, 8'b10000_001, 8'b01000_010, 8'b00100_011,
        8'b00010_100, 8'b10010_001, 8'b01100_010, 8'b00110_011,
        8'b00011_000, 8'b00001_000, 8'b11110_001
    };

    logic clk = 1'b0;
    logic rst;
    logic irq_i, f_valid_i, d_valid_i, e_valid_i, m_valid_i;
    logic [31:0] f_pc_i, d_pc_i, e_pc_i, m_pc_i;
    logic f_fetch_fault_i, d_illegal_i, e_overflow_i, m_data_fault_i;
    logic [3:0]  kill_o;
    logic        redirect_o, commit_ok_o;
    logic [2:0]  cause_o;
    logic [31:0] epc_o;

    int checks = 0;
    int errors = 0;
    logic [2:0]  exp_cause;
    logic [31:0] exp_epc;

    always #2.5 clk = ~clk;

    exc_commit_ctrl #(.PC_W(32), .HANDLER_PC(HANDLER)) dut (
        .clk(clk), .rst(rst), .irq_i(irq_i),
        .f_valid_i(f_valid_i), .d_valid_i(d_valid_i), .e_valid_i(e_valid_i), .m_valid_i(m_valid_i),
        .f_pc_i(f_pc_i), .d_pc_i(d_pc_i), .e_pc_i(e_pc_i), .m_pc_i(m_pc_i),
        .f_fetch_fault_i(f_fetch_fault_i), .d_illegal_i(d_illegal_i),
        .e_overflow_i(e_overflow_i), .m_data_fault_i(m_data_fault_i),
        .kill_o(kill_o), .redirect_o(redirect_o), .commit_ok_o(commit_ok_o),
        .cause_o(cause_o), .epc_o(epc_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic clear_in();
        irq_i = 0; f_valid_i = 0; d_valid_i = 0; e_valid_i = 0; m_valid_i = 0;
        f_pc_i = 32'h0; d_pc_i = 32'h0; e_pc_i = 32'h0; m_pc_i = 32'h0;
        f_fetch_fault_i = 0; d_illegal_i = 0; e_overflow_i = 0; m_data_fault_i = 0;
    endtask

    task automatic next_cycle();
        @(posedge clk); #1;
        clear_in();
    endtask

    task automatic chk_regs(input string req);
        chk(req, {29'd0, cause_o}, {29'd0, exp_cause});
        chk(req, epc_o, exp_epc);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        clear_in();
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        exp_cause = 3'd0;
        exp_epc   = 32'h0;

        // R10 reset state
        @(negedge clk);
        chk_regs("R10 reset");
        chk("R5 idle redirect", {31'd0, redirect_o}, 32'd0);
        chk("R5 idle kill", {28'd0, kill_o}, 32'd0);

        // Vector walk: one instruction through F, D, E, M (R1..R6, R10)
        for (int k = 0; k < NVEC; k++) begin
            logic [7:0]  v;
            logic [31:0] pc;
            logic        tr;
            v  = VEC[k];
            pc = 32'h1000 + k * 16;
            tr = |v[7:3];
            for (int c = 0; c < 4; c++) begin
                next_cycle();
                case (c)
                    0: begin f_valid_i = 1; f_pc_i = pc; f_fetch_fault_i = v[7]; end
                    1: begin d_valid_i = 1; d_pc_i = pc; d_illegal_i = v[6]; end
                    2: begin e_valid_i = 1; e_pc_i = pc; e_overflow_i = v[5]; end
                    default: begin m_valid_i = 1; m_pc_i = pc; m_data_fault_i = v[4]; irq_i = v[3]; end
                endcase
                @(negedge clk);
                if (c < 3) begin
                    chk("R1 early redirect", {31'd0, redirect_o}, 32'd0);
                end else begin
                    chk("R5 redirect", {31'd0, redirect_o}, {31'd0, tr});
                    chk("R5 kill", {28'd0, kill_o}, tr ? 32'hF : 32'h0);
                    chk("R6 commit_ok", {31'd0, commit_ok_o}, {31'd0, ~tr});
                end
            end
            next_cycle();
            @(negedge clk);
            if (tr) begin
                exp_cause = v[2:0];
                exp_epc   = pc;
                chk_regs(v[3] ? "R4 irq cause/epc" : "R2 R3 cause/epc");
            end else begin
                chk_regs("R10 hold");
            end
        end

        // R7: bubbles with fault lines high, then valid clean stages
        next_cycle();
        f_fetch_fault_i = 1; d_illegal_i = 1; e_overflow_i = 1; m_data_fault_i = 1;
        @(negedge clk);
        chk("R7 bubble redirect", {31'd0, redirect_o}, 32'd0);
        for (int c = 0; c < 3; c++) begin
            next_cycle();
            f_valid_i = 1; d_valid_i = 1; e_valid_i = 1; m_valid_i = 1;
            f_pc_i = 32'h50C; d_pc_i = 32'h508; e_pc_i = 32'h504; m_pc_i = 32'h500;
            @(negedge clk);
            chk("R7 no carried fault", {31'd0, redirect_o}, 32'd0);
            chk("R6 clean commit", {31'd0, commit_ok_o}, 32'd1);
        end
        next_cycle();
        @(negedge clk);
        chk_regs("R10 hold after bubbles");

        // R8: interrupt over empty memory stage
        next_cycle();
        irq_i = 1; e_valid_i = 1; e_pc_i = 32'h2008; d_valid_i = 1; d_pc_i = 32'h200C;
        f_valid_i = 1; f_pc_i = 32'h2010;
        @(negedge clk);
        chk("R8 redirect", {31'd0, redirect_o}, 32'd1);
        next_cycle();
        @(negedge clk);
        exp_cause = 3'd0; exp_epc = 32'h2008;
        chk_regs("R8 oldest valid pc");

        next_cycle();
        irq_i = 1; f_pc_i = 32'h3000;
        @(negedge clk);
        chk("R8 empty pipe kill", {28'd0, kill_o}, 32'hF);
        next_cycle();
        @(negedge clk);
        exp_cause = 3'd0; exp_epc = 32'h3000;
        chk_regs("R8 fetch pc");

        // R9: older data fault traps; younger illegal op must not survive
        next_cycle();
        m_valid_i = 1; m_pc_i = 32'h4000; m_data_fault_i = 1;
        e_valid_i = 1; e_pc_i = 32'h4004;
        d_valid_i = 1; d_pc_i = 32'h4008; d_illegal_i = 1;
        @(negedge clk);
        chk("R5 older trap", {31'd0, redirect_o}, 32'd1);
        next_cycle();
        e_valid_i = 1; e_pc_i = 32'h4008;
        @(negedge clk);
        exp_cause = 3'd4; exp_epc = 32'h4000;
        chk_regs("R2 older instruction cause");
        chk("R9 flushed record", {31'd0, redirect_o}, 32'd0);
        next_cycle();
        m_valid_i = 1; m_pc_i = 32'h4008;
        @(negedge clk);
        chk("R9 no stale trap", {31'd0, redirect_o}, 32'd0);
        chk("R9 commit after flush", {31'd0, commit_ok_o}, 32'd1);
        next_cycle();
        @(negedge clk);
        chk_regs("R10 hold after flush");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule